// File: doc/BRIEF.md
# Disk Drive Register File and Command Decoder

This block holds the per-drive registers of a bus that addresses up to eight disk drives. It decodes function commands written by a host channel. A host selects a drive and one of eight register addresses, then issues a write strobe, a read strobe, or both. Reads return data one cycle later on a registered port. Each drive keeps its own command, status, error, desired-address and attention state. One attention summary register spans every drive.

Control writes decode a five-bit function field. No-op, drive clear, preset and illegal codes finish at once inside the block. Search, read, write and write-check leave the drive busy and send a one-cycle start pulse to a sector datapath, which lies outside this block. The datapath ends the command with a per-drive done pulse. A drive stays busy until that pulse arrives, and while it is busy every write except one to the attention summary is refused and flagged.

Top module: `disk_reg_decoder`

## Requirements
- R1: After reset every drive is idle and ready, with no attention, a zero error register and a zero desired address. The read port, the start pulse, the completion pulses and the attention vector are all low.
- R2: A control write (address 0) with bit 0 clear stores bits 5:1 as the function field and starts nothing. Reading the control register then returns the function in bits 5:1, a 1 in bit 0 (idle), and bit 11 set while media is present.
- R3: A control write with bit 0 set and function 014 (search), 024 (write check), 030 (write) or 034 (read), all octal, is accepted only on a ready drive. In the next cycle the block gives a one-cycle start pulse carrying the drive number and function. The drive then reads bit 0 as 0, sets status bit 13 (positioning) and clears status bit 7 (ready). A done pulse on that drive restores ready, clears busy and positioning, and pulses that drive's completion output. If the last-sector flag came with the done pulse, status bit 10 is set. A search completion also raises attention.
- R4: While a drive is busy, a write to any address other than 4 leaves its registers unchanged and sets error-1 bit 2 and status bit 14.
- R5: A control write to a drive that is not ready, or whose media is absent, is refused with the same error-1 bit 2 and status bit 14.
- R6: An accepted command with bit 0 set (R3) clears error register 1, the status error bit and the last-sector bit. If its function code is not one of 00, 04, 010, 014, 024, 030 or 034, it then sets error-1 to 1 (bit 0), the error bit and attention, and starts nothing.
- R7: Preset (function 010) zeroes the desired sector/track register, sets status bit 6 (volume valid) and attention, and pulses the drive's completion output in the next cycle.
- R8: Drive clear (function 04) clears attention on the selected drive only and leaves the drive ready.
- R9: Address 4 reads as one attention bit per drive, with drive n in bit n. A write to address 4 clears attention on every drive whose data bit is 1. This write is accepted while a drive is busy.
- R10: Writing error register 1 (address 2) stores the value. A nonzero value sets status bit 14 and a zero value does not.
- R11: A write to an address above 7 sets error-1 bit 1 and status bit 14. A read of an address above 7 returns 0 and sets error-1 bit 1 only.
- R12: Address 6 reads 020003 octal. Addresses 3 and 7 read 0. While the selected drive's media is absent, every address except 4 reads 0.
- R13: The status register (address 1) has these bits: 15 attention, 14 error, 13 positioning, 12 online, 11 write-locked (media present and protect input high), 10 last sector, 8 present, 7 ready, 6 volume valid. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_sel | input | DRV_W | Drive addressed by the access |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data, valid the cycle after reg_rd |
| media_ok | input | NUM_DRIVES | Media present, per drive |
| wr_protect | input | NUM_DRIVES | Write-protect input, per drive |
| xfer_done | input | NUM_DRIVES | Datapath completion pulse, per drive |
| xfer_last | input | NUM_DRIVES | Last-sector flag given with xfer_done |
| start_pulse | output | 1 | One-cycle request to the datapath |
| start_drive | output | DRV_W | Drive being started |
| start_func | output | 5 | Function being started |
| op_done | output | NUM_DRIVES | One-cycle completion pulse, per drive |
| attn_vec | output | NUM_DRIVES | Attention bit of each drive |
| attn_any | output | 1 | OR of all attention bits |

## Verification
The embedded properties check, on every cycle, that a busy drive is never ready and never changes its desired address. They also check that a refused write always leaves both error flags set, that at most one start pulse is active, that a start pulse only comes from a busy drive, and that an illegal-address read returns zero. The bench scenarios are needed for the rest: the exact read-back of every register field, how a done pulse, a summary clear and a refused write interact in the same cycle, and the effect of media loss followed by its return. A reference model in the bench covers all of these.

// File: rtl/dkreg_pkg.sv
package dkreg_pkg;
  localparam int DATA_W = 16;
  localparam int FN_W   = 5;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_STAT  = 3'd1;
  localparam logic [2:0] REG_ERR1  = 3'd2;
  localparam logic [2:0] REG_MAINT = 3'd3;
  localparam logic [2:0] REG_ATTN  = 3'd4;
  localparam logic [2:0] REG_ADDR  = 3'd5;
  localparam logic [2:0] REG_TYPE  = 3'd6;
  localparam logic [2:0] REG_LOOK  = 3'd7;

  localparam logic [FN_W-1:0] FN_NOP    = 5'o00;
  localparam logic [FN_W-1:0] FN_DCLR   = 5'o04;
  localparam logic [FN_W-1:0] FN_PRESET = 5'o10;
  localparam logic [FN_W-1:0] FN_SEARCH = 5'o14;
  localparam logic [FN_W-1:0] FN_WCHK   = 5'o24;
  localparam logic [FN_W-1:0] FN_WRITE  = 5'o30;
  localparam logic [FN_W-1:0] FN_READ   = 5'o34;

  localparam int E1_ILF = 0;
  localparam int E1_ILR = 1;
  localparam int E1_RMR = 2;

  localparam logic [DATA_W-1:0] TYPE_CODE = 16'o020003;

  typedef struct packed {
    logic              go;
    logic [FN_W-1:0]   func;
    logic              ready;
    logic              pip;
    logic              attn;
    logic              vv;
    logic              lst;
    logic              err;
    logic [DATA_W-1:0] err1;
    logic [DATA_W-1:0] da;
  } drv_view_t;
endpackage

// File: rtl/dkreg_drive.sv
module dkreg_drive
  import dkreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic [2:0]        addr_lo,
  input  logic              addr_bad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              attn_clr,
  input  logic              media,
  input  logic              xfer_done,
  input  logic              xfer_last,
  output drv_view_t         view,
  output logic              start_o,
  output logic              done_o
);
  drv_view_t       st;
  logic [FN_W-1:0] wfn;
  logic            wgo;
  logic            is_attn_addr;

  assign view         = st;
  assign wfn          = wdata[FN_W:1];
  assign wgo          = wdata[0];
  assign is_attn_addr = !addr_bad && (addr_lo == REG_ATTN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= '0;
      st.ready <= 1'b1;
      start_o  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      start_o <= 1'b0;
      done_o  <= 1'b0;
      if (attn_clr) st.attn <= 1'b0;
      // completion from the datapath wins over a summary clear
      if (xfer_done && st.go) begin
        st.go    <= 1'b0;
        st.pip   <= 1'b0;
        st.ready <= 1'b1;
        done_o   <= 1'b1;
        if (xfer_last) st.lst <= 1'b1;
        if (st.func == FN_SEARCH) st.attn <= 1'b1;
      end
      if (rd_hit && addr_bad && media) st.err1[E1_ILR] <= 1'b1;
      if (wr_hit) begin
        if (st.go && !is_attn_addr) begin
          st.err1[E1_RMR] <= 1'b1;
          st.err          <= 1'b1;
        end else if (addr_bad) begin
          st.err1[E1_ILR] <= 1'b1;
          st.err          <= 1'b1;
        end else begin
          case (addr_lo)
            REG_CTRL: begin
              if (!(st.ready && media)) begin
                st.err1[E1_RMR] <= 1'b1;
                st.err          <= 1'b1;
              end else begin
                st.func <= wfn;
                if (wgo) begin
                  st.err1 <= '0;
                  st.err  <= 1'b0;
                  st.lst  <= 1'b0;
                  st.pip  <= 1'b0;
                  case (wfn)
                    FN_NOP: st.ready <= 1'b1;
                    FN_DCLR: begin
                      st.ready <= 1'b1;
                      st.attn  <= 1'b0;
                      st.go    <= 1'b0;
                    end
                    FN_PRESET: begin
                      st.da    <= '0;
                      st.vv    <= media;
                      st.ready <= 1'b1;
                      st.attn  <= 1'b1;
                      done_o   <= 1'b1;
                    end
                    FN_SEARCH, FN_WCHK, FN_WRITE, FN_READ: begin
                      st.go    <= 1'b1;
                      st.pip   <= 1'b1;
                      st.ready <= 1'b0;
                      start_o  <= 1'b1;
                    end
                    default: begin
                      st.ready <= 1'b1;
                      st.err   <= 1'b1;
                      st.attn  <= 1'b1;
                      st.err1  <= DATA_W'(1);
                    end
                  endcase
                end
              end
            end
            REG_ERR1: begin
              st.err1 <= wdata;
              if (wdata != '0) st.err <= 1'b1;
            end
            REG_ADDR: st.da <= wdata;
            default: ;
          endcase
        end
      end
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    st.go |-> !st.ready); // R3
  AST_START_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_o |-> st.go); // R3
  AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && st.go && !is_attn_addr) |=> (st.err1[E1_RMR] && st.err)); // R4
  AST_BUSY_DA_STABLE: assert property (@(posedge clk) disable iff (rst)
    st.go |=> $stable(st.da)); // R4
  AST_PRESET_RESULT: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !addr_bad && addr_lo == REG_CTRL && !st.go && st.ready && media
     && wgo && wfn == FN_PRESET) |=> (st.da == '0 && st.attn && st.vv && done_o)); // R7
endmodule

// File: rtl/dkreg_rdmux.sv
module dkreg_rdmux
  import dkreg_pkg::*;
#(
  parameter int NUM_DRIVES = 8,
  parameter int DRV_W      = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic [DRV_W-1:0]           sel,
  input  logic [2:0]                 addr_lo,
  input  logic                       addr_bad,
  input  drv_view_t [NUM_DRIVES-1:0] views,
  input  logic [NUM_DRIVES-1:0]      media,
  input  logic [NUM_DRIVES-1:0]      wprot,
  output logic [DATA_W-1:0]          rd_data
);
  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] attn_bits;
  drv_view_t         v;
  logic              m;
  logic              wp;

  always_comb begin
    attn_bits = '0;
    for (int i = 0; i < NUM_DRIVES; i++) attn_bits[i] = views[i].attn;
    v  = views[sel];
    m  = media[sel];
    wp = wprot[sel];
    nxt = '0;
    if (addr_bad) nxt = '0;
    else if (addr_lo == REG_ATTN) nxt = attn_bits;
    else if (!m) nxt = '0;
    else begin
      case (addr_lo)
        REG_CTRL: nxt = {4'b0, 1'b1, 5'b0, v.func, ~v.go};
        REG_STAT: nxt = {v.attn, v.err, v.pip, 1'b1, wp, v.lst, 1'b0, 1'b1,
                         v.ready, v.vv, 6'b0};
        REG_ERR1: nxt = v.err1;
        REG_ADDR: nxt = v.da;
        REG_TYPE: nxt = TYPE_CODE;
        default:  nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= nxt;
  end

  AST_BAD_ADDR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr_bad) |=> (rd_data == '0)); // R11
endmodule

// File: rtl/disk_reg_decoder.sv
module disk_reg_decoder
  import dkreg_pkg::*;
#(
  parameter int NUM_DRIVES = 8,
  parameter int ADDR_W     = 5,
  localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DRV_W-1:0]      drv_sel,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [NUM_DRIVES-1:0] media_ok,
  input  logic [NUM_DRIVES-1:0] wr_protect,
  input  logic [NUM_DRIVES-1:0] xfer_done,
  input  logic [NUM_DRIVES-1:0] xfer_last,
  output logic                  start_pulse,
  output logic [DRV_W-1:0]      start_drive,
  output logic [FN_W-1:0]       start_func,
  output logic [NUM_DRIVES-1:0] op_done,
  output logic [NUM_DRIVES-1:0] attn_vec,
  output logic                  attn_any
);
  drv_view_t [NUM_DRIVES-1:0] views;
  logic [NUM_DRIVES-1:0]      start_vec;
  logic [2:0]                 addr_lo;
  logic                       addr_bad;
  logic                       summary_wr;

  assign addr_lo    = reg_addr[2:0];
  assign addr_bad   = (reg_addr > ADDR_W'(7));
  assign summary_wr = reg_wr && !addr_bad && (addr_lo == REG_ATTN);

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
    logic hit;
    assign hit = (drv_sel == DRV_W'(g));
    dkreg_drive u_drv (
      .clk       (clk),
      .rst       (rst),
      .wr_hit    (reg_wr && hit),
      .rd_hit    (reg_rd && hit),
      .addr_lo   (addr_lo),
      .addr_bad  (addr_bad),
      .wdata     (wr_data),
      .attn_clr  (summary_wr && wr_data[g]),
      .media     (media_ok[g]),
      .xfer_done (xfer_done[g]),
      .xfer_last (xfer_last[g]),
      .view      (views[g]),
      .start_o   (start_vec[g]),
      .done_o    (op_done[g])
    );
    assign attn_vec[g] = views[g].attn;
  end

  dkreg_rdmux #(.NUM_DRIVES(NUM_DRIVES), .DRV_W(DRV_W)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (reg_rd),
    .sel      (drv_sel),
    .addr_lo  (addr_lo),
    .addr_bad (addr_bad),
    .views    (views),
    .media    (media_ok),
    .wprot    (wr_protect),
    .rd_data  (rd_data)
  );

  always_comb begin
    start_drive = '0;
    for (int i = 0; i < NUM_DRIVES; i++)
      if (start_vec[i]) start_drive = DRV_W'(i);
  end

  assign start_pulse = |start_vec;
  assign start_func  = views[start_drive].func;
  assign attn_any    = |attn_vec;

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start_vec)); // R3
endmodule

// File: tb/disk_reg_decoder_tb_top.sv
`timescale 1ns/1ps
module disk_reg_decoder_tb_top;
  import dkreg_pkg::*;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [2:0]   drv_sel = '0;
  logic [4:0]   reg_addr = '0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0]  wr_data = '0;
  logic [15:0]  rd_data;
  logic [N-1:0] media_ok = '1, wr_protect = 8'h40;
  logic [N-1:0] xfer_done = '0, xfer_last = '0;
  logic         start_pulse;
  logic [2:0]   start_drive;
  logic [4:0]   start_func;
  logic [N-1:0] op_done, attn_vec;
  logic         attn_any;

  disk_reg_decoder dut_i (
    .clk(clk), .rst(rst), .drv_sel(drv_sel), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .wr_data(wr_data), .rd_data(rd_data),
    .media_ok(media_ok), .wr_protect(wr_protect), .xfer_done(xfer_done),
    .xfer_last(xfer_last), .start_pulse(start_pulse), .start_drive(start_drive),
    .start_func(start_func), .op_done(op_done), .attn_vec(attn_vec),
    .attn_any(attn_any)
  );

  bit          m_go[N], m_rdy[N], m_pip[N], m_attn[N], m_vv[N], m_lst[N], m_err[N];
  logic [4:0]  m_fn[N];
  logic [15:0] m_e1[N], m_da[N];
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_attn_vec();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = m_attn[i];
    return r;
  endfunction

  function automatic logic [15:0] mread(input int d, input logic [4:0] a);
    if (a > 5'd7) return 16'h0;
    if (a == 5'd4) return {8'h0, m_attn_vec()};
    if (!media_ok[d]) return 16'h0;
    case (a)
      5'd0: return {4'b0, 1'b1, 5'b0, m_fn[d], ~m_go[d]};
      5'd1: return {m_attn[d], m_err[d], m_pip[d], 1'b1, wr_protect[d], m_lst[d],
                    1'b0, 1'b1, m_rdy[d], m_vv[d], 6'b0};
      5'd2: return m_e1[d];
      5'd5: return m_da[d];
      5'd6: return 16'o020003;
      default: return 16'h0;
    endcase
  endfunction

  function automatic bit known_fn(input logic [4:0] f);
    return f == 5'o00 || f == 5'o04 || f == 5'o10 || f == 5'o14 ||
           f == 5'o24 || f == 5'o30 || f == 5'o34;
  endfunction

  task automatic op(input bit wr, input bit rd, input int d, input logic [4:0] a,
                    input logic [15:0] w, input logic [N-1:0] dn,
                    input logic [N-1:0] ls, input string tag);
    logic [15:0] er;
    bit es, g0;
    logic [4:0] esf, fn;
    logic [N-1:0] ed;
    er = mread(d, a);
    es = 0; esf = '0; ed = '0;
    g0 = m_go[d];
    for (int i = 0; i < N; i++) if (wr && a == 5'd4 && w[i]) m_attn[i] = 0;
    for (int i = 0; i < N; i++)
      if (dn[i] && m_go[i]) begin
        m_go[i] = 0; m_pip[i] = 0; m_rdy[i] = 1; ed[i] = 1;
        if (ls[i]) m_lst[i] = 1;
        if (m_fn[i] == 5'o14) m_attn[i] = 1;
      end
    if (rd && media_ok[d] && a > 5'd7) m_e1[d][1] = 1'b1;
    if (wr) begin
      fn = w[5:1];
      if (g0 && a != 5'd4) begin m_e1[d][2] = 1'b1; m_err[d] = 1; end
      else if (a > 5'd7) begin m_e1[d][1] = 1'b1; m_err[d] = 1; end
      else if (a == 5'd0) begin
        if (!(m_rdy[d] && media_ok[d])) begin m_e1[d][2] = 1'b1; m_err[d] = 1; end
        else begin
          m_fn[d] = fn;
          if (w[0]) begin
            m_e1[d] = '0; m_err[d] = 0; m_lst[d] = 0; m_pip[d] = 0;
            if (!known_fn(fn)) begin
              m_rdy[d] = 1; m_err[d] = 1; m_attn[d] = 1; m_e1[d] = 16'h1;
            end else if (fn == 5'o04) begin m_rdy[d] = 1; m_attn[d] = 0; end
            else if (fn == 5'o10) begin
              m_da[d] = '0; m_vv[d] = media_ok[d]; m_attn[d] = 1; ed[d] = 1;
            end else if (fn != 5'o00) begin
              m_go[d] = 1; m_pip[d] = 1; m_rdy[d] = 0; es = 1; esf = fn;
            end
          end
        end
      end
      else if (a == 5'd2) begin m_e1[d] = w; if (w != 0) m_err[d] = 1; end
      else if (a == 5'd5) m_da[d] = w;
    end
    drv_sel = 3'(d); reg_addr = a; reg_wr = wr; reg_rd = rd; wr_data = w;
    xfer_done = dn; xfer_last = ls;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; xfer_done = '0; xfer_last = '0;
    if (rd) chk(rd_data == er, tag, "read data", rd_data, er);
    chk(start_pulse == es, tag, "start pulse", 16'(start_pulse), 16'(es));
    if (es) begin
      chk(start_drive == 3'(d), tag, "start drive", 16'(start_drive), 16'(d));
      chk(start_func == esf, tag, "start func", 16'(start_func), 16'(esf));
    end
    chk(op_done == ed, tag, "completion", 16'(op_done), 16'(ed));
    chk(attn_vec == m_attn_vec(), tag, "attention", 16'(attn_vec), 16'(m_attn_vec()));
    chk(attn_any == |m_attn_vec(), tag, "attention any", 16'(attn_any), 16'(|m_attn_vec()));
  endtask

  task automatic rd(input int d, input logic [4:0] a, input string tag);
    op(0, 1, d, a, 16'h0, '0, '0, tag);
  endtask

  task automatic wrr(input int d, input logic [4:0] a, input logic [15:0] w, input string tag);
    op(1, 0, d, a, w, '0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not end actual=%h expected=%h", 16'h0, 16'h1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_go[i] = 0; m_rdy[i] = 1; m_pip[i] = 0; m_attn[i] = 0; m_vv[i] = 0;
      m_lst[i] = 0; m_err[i] = 0; m_fn[i] = '0; m_e1[i] = '0; m_da[i] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state at the ports
    chk(rd_data == 16'h0, "R1", "rd_data", rd_data, 16'h0);
    chk(start_pulse == 1'b0 && op_done == '0, "R1", "pulses", 16'(op_done), 16'h0);
    chk(attn_vec == '0, "R1", "attention", 16'(attn_vec), 16'h0);
    for (int a = 0; a < 8; a++) rd(0, 5'(a), "R1");
    rd(3, 5'd1, "R1");
    // R2: function stored without GO
    wrr(0, 5'd0, 16'h0038, "R2");
    rd(0, 5'd0, "R2");
    // R3: read command starts the datapath
    wrr(0, 5'd0, 16'h0039, "R3");
    rd(0, 5'd0, "R3");
    rd(0, 5'd1, "R13");
    // R4: refused writes while busy
    wrr(0, 5'd5, 16'h0123, "R4");
    rd(0, 5'd5, "R4");
    rd(0, 5'd2, "R4");
    wrr(0, 5'd0, 16'h0009, "R4");
    rd(0, 5'd1, "R4");
    // R9: summary write accepted while busy
    wrr(0, 5'd4, 16'h00FF, "R9");
    // R3: completion with last-sector flag
    op(0, 0, 0, 5'd0, 16'h0, 8'h01, 8'h01, "R3");
    rd(0, 5'd1, "R3");
    // R6: illegal function
    wrr(0, 5'd0, 16'h0005, "R6");
    rd(0, 5'd2, "R6");
    rd(0, 5'd1, "R6");
    rd(0, 5'd4, "R9");
    // R7: preset on drive 2
    wrr(2, 5'd5, 16'h0ABC, "R7");
    wrr(2, 5'd0, 16'h0011, "R7");
    rd(2, 5'd5, "R7");
    rd(2, 5'd1, "R7");
    // search on drive 5 raises attention at completion
    wrr(5, 5'd0, 16'h0019, "R3");
    op(0, 0, 5, 5'd0, 16'h0, 8'h20, 8'h00, "R3");
    rd(5, 5'd4, "R9");
    // R8: drive clear on drive 5 only
    wrr(5, 5'd0, 16'h0009, "R8");
    rd(5, 5'd4, "R8");
    wrr(0, 5'd4, 16'h0001, "R9");
    // R10: error register writes
    wrr(2, 5'd2, 16'h0000, "R10");
    rd(2, 5'd1, "R10");
    wrr(3, 5'd2, 16'h0040, "R10");
    rd(3, 5'd1, "R10");
    // R11: illegal addresses
    op(0, 1, 4, 5'd12, 16'h0, '0, '0, "R11");
    rd(4, 5'd1, "R11");
    rd(4, 5'd2, "R11");
    wrr(4, 5'd20, 16'h0001, "R11");
    rd(4, 5'd1, "R11");
    // R12: constant registers and absent media
    rd(1, 5'd6, "R12");
    rd(1, 5'd3, "R12");
    rd(1, 5'd7, "R12");
    media_ok[1] = 1'b0;
    rd(1, 5'd6, "R12");
    rd(1, 5'd4, "R12");
    wrr(1, 5'd0, 16'h0039, "R5");
    media_ok[1] = 1'b1;
    rd(1, 5'd2, "R5");
    // R13: write-locked drive status
    rd(6, 5'd1, "R13");
    // random phase
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 3000; k++) begin
      int d, r;
      logic [4:0] a;
      logic [15:0] w;
      logic [N-1:0] dn, ls;
      bit wr, rdb;
      if ($urandom % 64 == 0) media_ok[$urandom % N] ^= 1'b1;
      if ($urandom % 64 == 0) wr_protect[$urandom % N] ^= 1'b1;
      d = $urandom % N;
      r = $urandom % 16;
      if (r < 6) a = 5'd0;
      else if (r < 8) a = 5'd4;
      else if (r < 9) a = 5'(8 + $urandom % 24);
      else a = 5'($urandom % 8);
      w = 16'($urandom);
      if (a == 5'd0) begin
        logic [4:0] f;
        case ($urandom % 8)
          0: f = 5'o00; 1: f = 5'o04; 2: f = 5'o10; 3: f = 5'o14;
          4: f = 5'o24; 5: f = 5'o30; 6: f = 5'o34; default: f = 5'($urandom);
        endcase
        w = {10'($urandom), f, 1'($urandom % 4 != 0)};
      end
      dn = '0; ls = '0;
      for (int i = 0; i < N; i++)
        if (m_go[i] && $urandom % 4 == 0) begin dn[i] = 1; ls[i] = 1'($urandom); end
      wr = ($urandom % 4) != 0;
      rdb = ($urandom % 2) != 0;
      op(wr, rdb, d, a, w, dn, ls, "RND");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule